// File: doc/BRIEF.md
# USB Serial Transceiver Macrocell

This block is the bit-level half of a USB device link, modelled on a single clock. On one side it talks to a byte-wide packet engine through separate 8-bit receive and transmit buses with their handshakes. On the other side it drives and samples a differential line pair. A clock-enable input, `bit_ce`, marks each serial bit time. The byte rate is one eighth of that rate and needs no separate strobe.

Receive and transmit share one state machine, so the block works half duplex. From idle it either hunts for SYNC in the decoded line bits or starts a transmission when the packet engine asks for one. A reception decodes NRZI, drops stuffed bits, assembles bytes LSB first and presents each one with a single-cycle strobe until EOP. A transmission sends SYNC, pulls bytes with a ready pulse, serializes them with stuffing and NRZI coding, and closes with EOP. If the engine withdraws its request before the first byte is taken, the packet is aborted and no EOP is sent.

Top module: `usbx_macrocell`

## Requirements
- R1: After reset the following hold. `rx_active`, `rx_valid`, `rx_error`, `tx_ready` and `line_tx_oe` are 0. The transmit pair shows the idle J state (`line_tx_dp`=1, `line_tx_dm`=0).
- R2: Line levels are J = (dp 1, dm 0), K = (0, 1) and SE0 = (0, 0). NRZI decoding gives 1 for no level change and 0 for a change. `rx_active` rises on the bit clock that completes SYNC, which is eight decoded bits forming 0x80 LSB first (seven 0s, then a 1). It falls on the first non-SE0 bit after SE0.
- R3: Received bytes are assembled LSB first. Each complete byte appears on `rx_data` with `rx_valid` high for exactly one clock, and only while `rx_active` is high.
- R4: On receive, a 0 that follows six consecutive 1s (the run counted from the first bit after SYNC) is discarded and not stored as data.
- R5: On receive, a 1 after six consecutive 1s pulses `rx_error` for one clock. In the same cycle `rx_active` drops, and no further byte of that packet is delivered. A later clean packet is then received normally.
- R6: A transmit request (`tx_valid`=1) is acted on only from idle. A request raised during a reception waits, and the line is not driven until the reception has ended.
- R7: A transmission drives the line with SYNC (0x80 LSB first), then each byte LSB first, all NRZI coded from J. `tx_ready` pulses for one clock each time a byte is taken from `tx_data`.
- R8: On transmit, a 0 is inserted after every six consecutive data 1s. This includes a run that ends on the last bit of the packet.
- R9: A packet ends after the last byte with two bit times of SE0 and one bit time of J. `line_tx_oe` then falls.
- R10: Dropping `tx_valid` before the first byte is taken aborts the packet. No byte is pulled, no SE0 is driven and `line_tx_oe` falls. The next request transmits normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_ce | input | 1 | One-clock enable per serial bit time |
| line_rx_dp | input | 1 | Received line, positive leg |
| line_rx_dm | input | 1 | Received line, negative leg |
| line_tx_dp | output | 1 | Driven line, positive leg |
| line_tx_dm | output | 1 | Driven line, negative leg |
| line_tx_oe | output | 1 | High while the block owns the line |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Packet engine requests or continues a transmission |
| tx_ready | output | 1 | One-clock pulse: `tx_data` has been taken |
| rx_data | output | 8 | Last received byte |
| rx_active | output | 1 | A packet is being received |
| rx_valid | output | 1 | One-clock pulse: `rx_data` holds a new byte |
| rx_error | output | 1 | One-clock pulse: stuffing violation |

## Verification
The hardest situations to reach are a transmit request that collides with an ongoing reception, and a request withdrawn while SYNC is still leaving the block. The first case needs two stimulus threads. One plays a host packet onto the receive pair. The other raises `tx_valid` halfway through that packet and samples the driven pair on every bit clock. The second case raises the request and drops it three bit times later, inside SYNC. The bench builds every expected line waveform with its own NRZI and stuffing encoder, and the same encoder produces the host packets. That encoder also produces a deliberately unstuffed run of ones to trigger the stuffing error.

// File: rtl/usbx_pkg.sv
`timescale 1ns/1ps
package usbx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RSYNC,
        ST_RDATA,
        ST_REOP,
        ST_TSYNC_LOAD,
        ST_TSYNC,
        ST_TDATA,
        ST_TEOP,
        ST_ERR
    } xcvr_state_e;

    typedef enum logic [1:0] {
        TXC_J,
        TXC_BIT,
        TXC_SE0
    } tx_cmd_e;

    // NRZI: a one keeps the level, a zero flips it
    function automatic logic nrzi_level(input logic cur_lvl, input logic data_bit);
        return data_bit ? cur_lvl : !cur_lvl;
    endfunction

endpackage

// File: rtl/usbx_rx_front.sv
`timescale 1ns/1ps
module usbx_rx_front (
    input  logic clk,
    input  logic rst,
    input  logic bit_ce,
    input  logic line_dp,
    input  logic line_dm,
    output logic se0,
    output logic dec_bit
);
    logic prev_lvl;

    assign se0     = !line_dp && !line_dm;
    assign dec_bit = (line_dp == prev_lvl);

    // after SE0 the line returns to J, so the reference level is J
    always_ff @(posedge clk) begin
        if (rst)
            prev_lvl <= 1'b1;
        else if (bit_ce)
            prev_lvl <= se0 ? 1'b1 : line_dp;
    end
endmodule

// File: rtl/usbx_run_counter.sv
`timescale 1ns/1ps
module usbx_run_counter #(
    parameter int LIMIT = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    input  logic bit_in,
    output logic full
);
    localparam int RUN_W = $clog2(LIMIT + 2);

    logic [RUN_W-1:0] run;

    assign full = (run == RUN_W'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || clr)
            run <= '0;
        else if (step)
            run <= bit_in ? run + 1'b1 : '0;
    end
endmodule

// File: rtl/usbx_tx_line.sv
`timescale 1ns/1ps
module usbx_tx_line
    import usbx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bit_ce,
    input  tx_cmd_e cmd,
    input  logic    cmd_bit,
    output logic    line_dp,
    output logic    line_dm
);
    logic lvl;
    logic se0_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl   <= 1'b1;
            se0_q <= 1'b0;
        end else if (bit_ce) begin
            case (cmd)
                TXC_BIT: begin
                    se0_q <= 1'b0;
                    lvl   <= nrzi_level(lvl, cmd_bit);
                end
                TXC_SE0: begin
                    se0_q <= 1'b1;
                    lvl   <= 1'b1;
                end
                default: begin
                    se0_q <= 1'b0;
                    lvl   <= 1'b1;
                end
            endcase
        end
    end

    assign line_dp = lvl && !se0_q;
    assign line_dm = !lvl && !se0_q;
endmodule

// File: rtl/usbx_macrocell.sv
`timescale 1ns/1ps
module usbx_macrocell
    import usbx_pkg::*;
#(
    parameter int BYTE_W       = 8,
    parameter int STUFF_RUN    = 6,
    parameter int EOP_SE0_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_ce,
    input  logic              line_rx_dp,
    input  logic              line_rx_dm,
    output logic              line_tx_dp,
    output logic              line_tx_dm,
    output logic              line_tx_oe,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_active,
    output logic              rx_valid,
    output logic              rx_error
);
    localparam int                CNT_W     = $clog2(BYTE_W);
    localparam int                EOP_W     = $clog2(EOP_SE0_BITS + 2);
    localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(BYTE_W - 1);
    localparam logic [EOP_W-1:0]  EOP_J_IDX = EOP_W'(EOP_SE0_BITS);
    localparam logic [EOP_W-1:0]  EOP_END   = EOP_W'(EOP_SE0_BITS + 1);
    localparam logic [BYTE_W-1:0] SYNC_WORD = {1'b1, {(BYTE_W-1){1'b0}}};

    xcvr_state_e       state;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] rx_shift;
    logic [CNT_W-1:0]  rx_cnt;
    logic [BYTE_W-1:0] tx_sh;
    logic [CNT_W-1:0]  tx_cnt;
    logic [EOP_W-1:0]  eop_cnt;

    logic    se0;
    logic    dec_bit;
    logic    run_clr;
    logic    run_step;
    logic    run_bit;
    logic    run_full;
    tx_cmd_e tx_cmd;
    logic    tx_cmd_bit;

    usbx_rx_front u_rx_front (
        .clk     (clk),
        .rst     (rst),
        .bit_ce  (bit_ce),
        .line_dp (line_rx_dp),
        .line_dm (line_rx_dm),
        .se0     (se0),
        .dec_bit (dec_bit)
    );

    // one run counter serves both directions: the FSM is never in both
    usbx_run_counter #(.LIMIT(STUFF_RUN)) u_run (
        .clk    (clk),
        .rst    (rst),
        .clr    (run_clr),
        .step   (run_step),
        .bit_in (run_bit),
        .full   (run_full)
    );

    usbx_tx_line u_tx_line (
        .clk     (clk),
        .rst     (rst),
        .bit_ce  (bit_ce),
        .cmd     (tx_cmd),
        .cmd_bit (tx_cmd_bit),
        .line_dp (line_tx_dp),
        .line_dm (line_tx_dm)
    );

    assign rx_shift = {dec_bit, rx_sh[BYTE_W-1:1]};

    always_comb begin
        run_clr    = 1'b1;
        run_step   = 1'b0;
        run_bit    = 1'b0;
        tx_cmd     = TXC_J;
        tx_cmd_bit = 1'b1;
        case (state)
            ST_RSYNC, ST_RDATA: begin
                run_clr  = 1'b0;
                run_step = bit_ce && !se0;
                run_bit  = dec_bit;
            end
            ST_TSYNC: begin
                if (tx_valid) begin
                    tx_cmd     = TXC_BIT;
                    tx_cmd_bit = tx_sh[0];
                end
            end
            ST_TDATA: begin
                run_clr    = 1'b0;
                run_step   = bit_ce;
                tx_cmd     = TXC_BIT;
                tx_cmd_bit = run_full ? 1'b0 : tx_sh[0];
                run_bit    = tx_cmd_bit;
            end
            ST_TEOP: begin
                run_clr  = 1'b0;
                run_step = bit_ce && run_full;
                if (run_full) begin
                    tx_cmd     = TXC_BIT;
                    tx_cmd_bit = 1'b0;
                end else if (eop_cnt < EOP_J_IDX) begin
                    tx_cmd = TXC_SE0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            rx_sh      <= '1;
            rx_cnt     <= '0;
            rx_data    <= '0;
            rx_active  <= 1'b0;
            rx_valid   <= 1'b0;
            rx_error   <= 1'b0;
            tx_sh      <= '0;
            tx_cnt     <= '0;
            tx_ready   <= 1'b0;
            eop_cnt    <= '0;
            line_tx_oe <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            rx_error <= 1'b0;
            tx_ready <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (tx_valid) begin
                        state <= ST_TSYNC_LOAD;
                    end else if (bit_ce && !se0) begin
                        rx_sh <= rx_shift;
                        if (rx_shift == SYNC_WORD) begin
                            state     <= ST_RSYNC;
                            rx_active <= 1'b1;
                            rx_cnt    <= '0;
                        end
                    end
                end
                ST_RSYNC, ST_RDATA: begin
                    if (bit_ce) begin
                        if (se0) begin
                            state <= ST_REOP;
                        end else if (run_full) begin
                            if (dec_bit) begin
                                state     <= ST_ERR;
                                rx_error  <= 1'b1;
                                rx_active <= 1'b0;
                            end
                        end else begin
                            rx_sh <= rx_shift;
                            if (rx_cnt == LAST_BIT) begin
                                rx_data  <= rx_shift;
                                rx_valid <= 1'b1;
                                rx_cnt   <= '0;
                                state    <= ST_RDATA;
                            end else begin
                                rx_cnt <= rx_cnt + 1'b1;
                            end
                        end
                    end
                end
                ST_REOP: begin
                    if (bit_ce && !se0) begin
                        state     <= ST_IDLE;
                        rx_active <= 1'b0;
                        rx_sh     <= '1;
                    end
                end
                ST_TSYNC_LOAD: begin
                    if (!tx_valid) begin
                        state <= ST_ERR;
                    end else begin
                        tx_sh      <= SYNC_WORD;
                        tx_cnt     <= '0;
                        line_tx_oe <= 1'b1;
                        state      <= ST_TSYNC;
                    end
                end
                ST_TSYNC: begin
                    if (!tx_valid) begin
                        state      <= ST_ERR;
                        line_tx_oe <= 1'b0;
                    end else if (bit_ce) begin
                        if (tx_cnt == LAST_BIT) begin
                            tx_sh    <= tx_data;
                            tx_ready <= 1'b1;
                            tx_cnt   <= '0;
                            state    <= ST_TDATA;
                        end else begin
                            tx_sh  <= tx_sh >> 1;
                            tx_cnt <= tx_cnt + 1'b1;
                        end
                    end
                end
                ST_TDATA: begin
                    if (bit_ce && !run_full) begin
                        if (tx_cnt == LAST_BIT) begin
                            tx_cnt <= '0;
                            if (tx_valid) begin
                                tx_sh    <= tx_data;
                                tx_ready <= 1'b1;
                            end else begin
                                eop_cnt <= '0;
                                state   <= ST_TEOP;
                            end
                        end else begin
                            tx_sh  <= tx_sh >> 1;
                            tx_cnt <= tx_cnt + 1'b1;
                        end
                    end
                end
                ST_TEOP: begin
                    if (bit_ce && !run_full) begin
                        if (eop_cnt == EOP_END) begin
                            line_tx_oe <= 1'b0;
                            rx_sh      <= '1;
                            state      <= ST_IDLE;
                        end else begin
                            eop_cnt <= eop_cnt + 1'b1;
                        end
                    end
                end
                ST_ERR: begin
                    line_tx_oe <= 1'b0;
                    rx_active  <= 1'b0;
                    if (bit_ce && !tx_valid) begin
                        rx_sh <= '1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/usbx_macrocell_chk.sv
`timescale 1ns/1ps
module usbx_macrocell_chk (
    input logic clk,
    input logic rst,
    input logic bit_ce,
    input logic line_tx_dp,
    input logic line_tx_dm,
    input logic line_tx_oe,
    input logic tx_valid,
    input logic tx_ready,
    input logic rx_active,
    input logic rx_valid,
    input logic rx_error
);
    p_rxvalid_in_packet_r3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> rx_active);

    p_rxvalid_single_r3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    p_error_ends_rx_r5: assert property (@(posedge clk) disable iff (rst)
        rx_error |-> !rx_active);

    p_no_drive_in_rx_r6: assert property (@(posedge clk) disable iff (rst)
        line_tx_oe |-> !rx_active);

    p_ready_single_r7: assert property (@(posedge clk) disable iff (rst)
        tx_ready |=> !tx_ready);

    p_ready_after_valid_r7: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> $past(tx_valid));

    p_line_moves_on_ce_r7: assert property (@(posedge clk) disable iff (rst)
        !bit_ce |=> $stable({line_tx_dp, line_tx_dm}));

    p_se0_only_driven_r9: assert property (@(posedge clk) disable iff (rst)
        (!line_tx_dp && !line_tx_dm) |-> line_tx_oe);
endmodule

bind usbx_macrocell usbx_macrocell_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_ce     (bit_ce),
    .line_tx_dp (line_tx_dp),
    .line_tx_dm (line_tx_dm),
    .line_tx_oe (line_tx_oe),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .rx_active  (rx_active),
    .rx_valid   (rx_valid),
    .rx_error   (rx_error)
);

// File: tb/tb_usbx_macrocell.sv
`timescale 1ns/1ps
module tb_usbx_macrocell;
    logic       clk = 1'b0;
    logic       rst;
    logic       bit_ce;
    logic       rx_dp, rx_dm;
    logic       line_tx_dp, line_tx_dm, line_tx_oe;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_active, rx_valid, rx_error;

    always #2.5 clk = ~clk;

    usbx_macrocell dut (
        .clk        (clk),
        .rst        (rst),
        .bit_ce     (bit_ce),
        .line_rx_dp (rx_dp),
        .line_rx_dm (rx_dm),
        .line_tx_dp (line_tx_dp),
        .line_tx_dm (line_tx_dm),
        .line_tx_oe (line_tx_oe),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .rx_data    (rx_data),
        .rx_active  (rx_active),
        .rx_valid   (rx_valid),
        .rx_error   (rx_error)
    );

    int nchk = 0;
    int nfail = 0;
    int ph = 0;
    int cyc = 0;

    logic [1:0] rec [0:1023];
    int         nrec;
    logic [7:0] got [0:63];
    int         ngot;
    int         nerr;
    int         nready;
    int         n_oe_rx;

    logic [7:0] pkt  [0:7];
    logic [7:0] rxb  [0:7];
    int         nrxb;
    logic [1:0] expl [0:255];
    int         nexp;
    logic [1:0] rxl  [0:255];
    int         nrxl;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // bit clock enable, monitors and watchdog, all at the falling edge
    initial begin
        bit_ce = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (bit_ce && line_tx_oe && nrec < 1024) begin
                rec[nrec] = {line_tx_dp, line_tx_dm};
                nrec++;
            end
            if (rx_valid && ngot < 64) begin
                got[ngot] = rx_data;
                ngot++;
            end
            if (rx_error) nerr++;
            if (tx_ready) nready++;
            if (line_tx_oe && rx_active) n_oe_rx++;
            ph = (ph + 1) % 4;
            bit_ce = (ph == 0);
            if (cyc > 150000) begin
                nchk++;
                nfail++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
                $display("[TB] %0d tests run, %0d failed", nchk, nfail);
                $finish;
            end
        end
    end

    task automatic clear_mon();
        nrec = 0; ngot = 0; nerr = 0; nready = 0; n_oe_rx = 0;
    endtask

    task automatic wait_ce(input int n);
        repeat (n) @(posedge clk iff bit_ce);
        #1;
    endtask

    // independent line model: SYNC, data LSB first, stuffing after six ones, EOP
    task automatic build(input int nb, input bit stuff_on);
        logic lvl;
        logic b;
        int   ones;
        nexp = 0;
        lvl  = 1'b1;
        for (int i = 0; i < 8; i++) begin
            b = (i == 7);
            if (!b) lvl = !lvl;
            expl[nexp] = {lvl, !lvl}; nexp++;
        end
        ones = 0;
        for (int k = 0; k < nb; k++) begin
            for (int i = 0; i < 8; i++) begin
                b = pkt[k][i];
                if (!b) lvl = !lvl;
                expl[nexp] = {lvl, !lvl}; nexp++;
                ones = b ? ones + 1 : 0;
                if (stuff_on && ones == 6) begin
                    lvl = !lvl;
                    expl[nexp] = {lvl, !lvl}; nexp++;
                    ones = 0;
                end
            end
        end
        expl[nexp] = 2'b00; nexp++;
        expl[nexp] = 2'b00; nexp++;
        expl[nexp] = 2'b10; nexp++;
    endtask

    task automatic load_rx(input int nb, input bit stuff_on);
        build(nb, stuff_on);
        for (int i = 0; i < nexp; i++) rxl[i] = expl[i];
        nrxl = nexp;
        for (int i = 0; i < nb; i++) rxb[i] = pkt[i];
        nrxb = nb;
    endtask

    task automatic drive_rx(input bit chk_active);
        for (int i = 0; i < nrxl; i++) begin
            @(posedge clk iff bit_ce);
            #1;
            if (chk_active && i == 7)
                chk(rx_active == 1'b0, "R2", "rx_active before SYNC end", rx_active, 0);
            if (chk_active && i == 8)
                chk(rx_active == 1'b1, "R2", "rx_active after SYNC", rx_active, 1);
            {rx_dp, rx_dm} = rxl[i];
        end
        wait_ce(3);
    endtask

    task automatic drive_tx(input int nb);
        int idx;
        @(posedge clk iff bit_ce);
        #1;
        idx      = 0;
        tx_data  = pkt[0];
        tx_valid = 1'b1;
        while (tx_valid) begin
            @(negedge clk);
            if (tx_ready) begin
                idx++;
                if (idx < nb) tx_data = pkt[idx];
                else tx_valid = 1'b0;
            end
        end
        while (line_tx_oe) @(negedge clk);
        wait_ce(2);
    endtask

    task automatic compare_tx(input string req);
        int bad;
        bad = -1;
        chk(nrec == nexp, req, "line bit count", nrec, nexp);
        for (int i = 0; i < nexp && i < nrec; i++)
            if (bad < 0 && rec[i] != expl[i]) bad = i;
        if (bad >= 0)
            chk(1'b0, req, $sformatf("line symbol at bit %0d", bad), rec[bad], expl[bad]);
        else
            chk(1'b1, req, "line symbols", 0, 0);
    endtask

    task automatic check_rx_bytes(input string req);
        chk(ngot == nrxb, req, "received byte count", ngot, nrxb);
        for (int i = 0; i < nrxb && i < ngot; i++)
            chk(got[i] == rxb[i], req, $sformatf("byte %0d", i), got[i], rxb[i]);
    endtask

    task automatic t_reset();
        rst = 1'b1; rx_dp = 1'b1; rx_dm = 1'b0; tx_valid = 1'b0; tx_data = '0;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rx_active == 0 && rx_valid == 0 && rx_error == 0, "R1", "rx outputs", {rx_active, rx_valid, rx_error}, 0);
        chk(tx_ready == 0 && line_tx_oe == 0, "R1", "tx_ready/oe", {tx_ready, line_tx_oe}, 0);
        chk({line_tx_dp, line_tx_dm} == 2'b10, "R1", "idle J", {line_tx_dp, line_tx_dm}, 2);
        wait_ce(4);
    endtask

    task automatic t_rx_basic();
        clear_mon();
        pkt[0] = 8'hA5; pkt[1] = 8'h3C;
        load_rx(2, 1'b1);
        drive_rx(1'b1);
        check_rx_bytes("R3");
        chk(rx_active == 1'b0, "R2", "rx_active after EOP", rx_active, 0);
        chk(nerr == 0, "R3", "no error", nerr, 0);
    endtask

    task automatic t_rx_stuff();
        clear_mon();
        pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h7E;
        load_rx(3, 1'b1);
        drive_rx(1'b0);
        check_rx_bytes("R4");
        chk(nerr == 0, "R4", "stuffed bits accepted", nerr, 0);
    endtask

    task automatic t_rx_stuff_err();
        clear_mon();
        pkt[0] = 8'hFF; pkt[1] = 8'hFF;
        load_rx(2, 1'b0);
        drive_rx(1'b0);
        chk(nerr == 1, "R5", "rx_error pulses", nerr, 1);
        chk(ngot == 0, "R5", "bytes after violation", ngot, 0);
        chk(rx_active == 1'b0, "R5", "rx_active after violation", rx_active, 0);
        wait_ce(4);
        clear_mon();
        pkt[0] = 8'h5A;
        load_rx(1, 1'b1);
        drive_rx(1'b0);
        check_rx_bytes("R5");
    endtask

    task automatic t_tx_basic();
        clear_mon();
        pkt[0] = 8'h3C; pkt[1] = 8'hA5;
        build(2, 1'b1);
        drive_tx(2);
        compare_tx("R7");
        chk(nready == 2, "R7", "tx_ready pulses", nready, 2);
        if (nrec >= 3) begin
            chk(rec[nrec-3] == 2'b00 && rec[nrec-2] == 2'b00, "R9", "two SE0 bits",
                {rec[nrec-3], rec[nrec-2]}, 0);
            chk(rec[nrec-1] == 2'b10, "R9", "J after SE0", rec[nrec-1], 2);
        end else begin
            chk(1'b0, "R9", "EOP present", nrec, 3);
        end
        chk(line_tx_oe == 1'b0, "R9", "oe released", line_tx_oe, 0);
    endtask

    task automatic t_tx_stuff();
        clear_mon();
        pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'hFC;
        build(3, 1'b1);
        drive_tx(3);
        compare_tx("R8");
        chk(nready == 3, "R8", "tx_ready pulses", nready, 3);
    endtask

    task automatic t_busy();
        clear_mon();
        pkt[0] = 8'h12; pkt[1] = 8'h34;
        load_rx(2, 1'b1);
        pkt[0] = 8'h55;
        build(1, 1'b1);
        fork
            drive_rx(1'b0);
            begin
                wait_ce(12);
                drive_tx(1);
            end
        join
        check_rx_bytes("R6");
        chk(n_oe_rx == 0, "R6", "line driven during reception", n_oe_rx, 0);
        compare_tx("R6");
    endtask

    task automatic t_abort();
        int nse0;
        clear_mon();
        @(posedge clk iff bit_ce);
        #1;
        tx_data  = 8'h99;
        tx_valid = 1'b1;
        wait_ce(3);
        tx_valid = 1'b0;
        wait_ce(4);
        nse0 = 0;
        for (int i = 0; i < nrec; i++) if (rec[i] == 2'b00) nse0++;
        chk(nready == 0, "R10", "bytes pulled on abort", nready, 0);
        chk(nse0 == 0, "R10", "SE0 bits on abort", nse0, 0);
        chk(line_tx_oe == 1'b0, "R10", "oe after abort", line_tx_oe, 0);
        clear_mon();
        pkt[0] = 8'hC3;
        build(1, 1'b1);
        drive_tx(1);
        compare_tx("R10");
        chk(nready == 1, "R10", "tx_ready after recovery", nready, 1);
    endtask

    initial begin
        rst = 1'b1; rx_dp = 1'b1; rx_dm = 1'b0; tx_valid = 1'b0; tx_data = '0;
        clear_mon();
        t_reset();
        t_rx_basic();
        t_rx_stuff();
        t_rx_stuff_err();
        t_tx_basic();
        t_tx_stuff();
        t_busy();
        t_abort();
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule